// File: doc/BRIEF.md
# Cascaded Synchronous BCD Decade Counter

This block is a synchronous decimal counter made of three chained decades. Each decade holds one BCD digit that steps from 0 to 9 and then back to 0. When the counter is enabled, the lowest decade advances on every clock. A higher decade advances only when every decade below it shows 9. The terminal carry output flags the cycle in which the whole count rolls over from 999 to 000, so a further counter can be chained onto it.

A parameter chooses how each decade computes its next state. The first option uses minimal per-bit toggle equations. The second option uses a four-bit incrementer that reloads zero instead of stepping past 9. Both options must produce exactly the same digit sequence. The reset is synchronous and active-high, and it clears every digit.

Top module: `bcd_chain_counter`

## Requirements
- R1: When `rst` is high at a rising clock edge, every digit reads 0 after that edge, regardless of `count_en`.
- R2: When `count_en` is low at a rising edge and reset is low, `digits_o` keeps its value across that edge.
- R3: When `count_en` is high at a rising edge, the lowest digit (`digits_o[3:0]`) moves from d to d+1 for d below 9, and from 9 to 0.
- R4: Decade k (bits 4k+3:4k) advances at an edge only if `count_en` is high and every lower digit is 9; otherwise it holds.
- R5: `carry_o` is a combinational output. It is 1 exactly when `count_en` is high and all three digits are 9.
- R6: An enabled edge while the count is 999 leaves the count at 000.
- R7: With either value of `STYLE` (0 = toggle equations, 1 = reload-on-nine incrementer), the count after n enabled edges since reset equals n modulo 1000, read as hundreds, tens, ones digits from the high bits to the low bits.
- R8: Every digit always holds a value from 0 to 9.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high clear of all digits |
| count_en | input | 1 | Count enable for the whole chain |
| digits_o | output | 12 | BCD digits: [11:8] hundreds, [7:4] tens, [3:0] ones |
| carry_o | output | 1 | Terminal carry, high when enabled at 999 |

## Verification
The digits are registered, so the effect of an enable or reset applied in one cycle shows up one clock edge later. The bench drives its inputs on the falling edge and reads the digits at the next falling edge, after exactly one rising edge. The carry is combinational, so it is read a short delay after the inputs are driven and before the rising edge. The bench keeps an integer reference count that it bumps on each enabled edge. It compares that count against one instance built with each style, which covers the 999-to-000 wrap and long runs of random enables.

// File: rtl/bcd_chain_pkg.sv
package bcd_chain_pkg;

    typedef logic [3:0] digit_t;

    typedef enum logic {
        STYLE_TOGGLE = 1'b0,
        STYLE_RELOAD = 1'b1
    } step_style_e;

    localparam digit_t DIGIT_MAX = 4'd9;

    // Per-bit toggle vector of a decade, ordered {b3, b2, b1, b0}.
    function automatic digit_t toggle_mask(input digit_t q);
        digit_t t;
        t[0] = 1'b1;
        t[1] = ~q[3] & q[0];
        t[2] = q[1] & q[0];
        t[3] = (q[3] & q[0]) | (q[2] & q[1] & q[0]);
        return t;
    endfunction

    // Terminal state of a decade: only 9 has both b3 and b0 set in 0..9.
    function automatic logic at_top(input digit_t q);
        return q[3] & q[0];
    endfunction

endpackage

// File: rtl/bcd_decade_toggle.sv
module bcd_decade_toggle
    import bcd_chain_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   step,
    output digit_t digit
);
    digit_t mask;

    always_comb mask = toggle_mask(digit) & {4{step}};

    always_ff @(posedge clk) begin
        if (rst) digit <= '0;
        else     digit <= digit ^ mask;
    end
endmodule

// File: rtl/bcd_decade_reload.sv
module bcd_decade_reload
    import bcd_chain_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   step,
    output digit_t digit
);
    logic wrap;

    always_comb wrap = (digit == DIGIT_MAX);

    always_ff @(posedge clk) begin
        if (rst)       digit <= '0;
        else if (step) digit <= wrap ? '0 : digit + 4'd1;
    end
endmodule

// File: rtl/bcd_decade.sv
module bcd_decade
    import bcd_chain_pkg::*;
#(
    parameter step_style_e STYLE = STYLE_TOGGLE
) (
    input  logic   clk,
    input  logic   rst,
    input  logic   step,
    output digit_t digit,
    output logic   top
);
    generate
        if (STYLE == STYLE_TOGGLE) begin : g_toggle
            bcd_decade_toggle u_dec (
                .clk   (clk),
                .rst   (rst),
                .step  (step),
                .digit (digit)
            );
        end else begin : g_reload
            bcd_decade_reload u_dec (
                .clk   (clk),
                .rst   (rst),
                .step  (step),
                .digit (digit)
            );
        end
    endgenerate

    always_comb top = at_top(digit);
endmodule

// File: rtl/bcd_chain_counter.sv
module bcd_chain_counter
    import bcd_chain_pkg::*;
#(
    parameter int          NUM_DECADES = 3,
    parameter step_style_e STYLE       = STYLE_TOGGLE,
    localparam int         DW          = 4 * NUM_DECADES
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          count_en,
    output logic [DW-1:0] digits_o,
    output logic          carry_o
);
    logic [NUM_DECADES:0]   step_chain;
    logic [NUM_DECADES-1:0] tops;

    assign step_chain[0] = count_en;

    generate
        for (genvar k = 0; k < NUM_DECADES; k++) begin : g_dec
            digit_t d;
            bcd_decade #(.STYLE(STYLE)) u_decade (
                .clk   (clk),
                .rst   (rst),
                .step  (step_chain[k]),
                .digit (d),
                .top   (tops[k])
            );
            assign step_chain[k+1] = step_chain[k] & tops[k];
            assign digits_o[4*k +: 4] = d;
        end
    endgenerate

    assign carry_o = step_chain[NUM_DECADES];
endmodule

// File: rtl/bcd_chain_checker.sv
module bcd_chain_checker #(
    parameter int  NUM_DECADES = 3,
    localparam int DW          = 4 * NUM_DECADES
) (
    input logic          clk,
    input logic          rst,
    input logic          count_en,
    input logic [DW-1:0] digits_o,
    input logic          carry_o
);
    logic [DW-1:0] all_nines;

    always_comb begin
        for (int k = 0; k < NUM_DECADES; k++) all_nines[4*k +: 4] = 4'd9;
    end

    // R1
    a_r1_reset_clears: assert property (@(posedge clk)
        rst |=> (digits_o == '0));

    // R2
    a_r2_hold_when_idle: assert property (@(posedge clk) disable iff (rst)
        !count_en |=> $stable(digits_o));

    // R3
    a_r3_ones_step: assert property (@(posedge clk) disable iff (rst)
        (count_en && digits_o[3:0] != 4'd9) |=> (digits_o[3:0] == $past(digits_o[3:0]) + 4'd1));

    // R3
    a_r3_ones_wrap: assert property (@(posedge clk) disable iff (rst)
        (count_en && digits_o[3:0] == 4'd9) |=> (digits_o[3:0] == 4'd0));

    // R4
    a_r4_tens_waits: assert property (@(posedge clk) disable iff (rst)
        (digits_o[3:0] != 4'd9) |=> $stable(digits_o[DW-1:4]));

    // R5
    a_r5_carry_match: assert property (@(posedge clk) disable iff (rst)
        carry_o == (count_en && digits_o == all_nines));

    // R6
    a_r6_full_wrap: assert property (@(posedge clk) disable iff (rst)
        carry_o |=> (digits_o == '0));

    generate
        for (genvar k = 0; k < NUM_DECADES; k++) begin : g_rng
            // R8
            a_r8_digit_range: assert property (@(posedge clk) disable iff (rst)
                digits_o[4*k +: 4] <= 4'd9);
        end
    endgenerate
endmodule

bind bcd_chain_counter bcd_chain_checker #(.NUM_DECADES(NUM_DECADES)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .count_en (count_en),
    .digits_o (digits_o),
    .carry_o  (carry_o)
);

// File: tb/bcd_chain_counter_test.sv
module bcd_chain_counter_test;
    import bcd_chain_pkg::*;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        count_en = 1'b0;
    logic [11:0] dig_a, dig_b;
    logic        cy_a, cy_b;
    int          ref_count = 0;
    int          applied = 0;
    int          wrong = 0;
    bit          finished = 1'b0;

    always #2 clk = ~clk;

    bcd_chain_counter #(.NUM_DECADES(3), .STYLE(STYLE_TOGGLE)) uut (
        .clk(clk), .rst(rst), .count_en(count_en), .digits_o(dig_a), .carry_o(cy_a));

    bcd_chain_counter #(.NUM_DECADES(3), .STYLE(STYLE_RELOAD)) uut_b (
        .clk(clk), .rst(rst), .count_en(count_en), .digits_o(dig_b), .carry_o(cy_b));

    function automatic logic [11:0] to_bcd(input int v);
        return {4'(v / 100), 4'((v / 10) % 10), 4'(v % 10)};
    endfunction

    task automatic check_digits(input string req);
        logic [11:0] exp = to_bcd(ref_count);
        applied++;
        if (dig_a !== exp) begin
            wrong++;
            $display("FAIL %s toggle style digits %h expected %h", req, dig_a, exp);
        end
        applied++;
        if (dig_b !== exp) begin
            wrong++;
            $display("FAIL %s reload style digits %h expected %h", req, dig_b, exp);
        end
    endtask

    // Starts and ends on a falling edge.
    task automatic tick(input logic r, input logic e, input string req);
        logic exp_cy;
        rst = r;
        count_en = e;
        #1;
        if (!r) begin
            exp_cy = e && (ref_count == 999); // R5
            applied++;
            if (cy_a !== exp_cy || cy_b !== exp_cy) begin
                wrong++;
                $display("FAIL R5 carry %b/%b expected %b", cy_a, cy_b, exp_cy);
            end
        end
        @(posedge clk);
        if (r)      ref_count = 0;
        else if (e) ref_count = (ref_count + 1) % 1000;
        @(negedge clk);
        check_digits(req);
    endtask

    initial begin
        int unused_seed;
        unused_seed = $urandom(32'd2718);
        @(negedge clk);
        // R1 reset state, with enable high as well
        tick(1'b1, 1'b1, "R1");
        tick(1'b1, 1'b0, "R1");
        // R3 ones digit through 0..9 and back to 0; R4 tens moves only at 9
        for (int i = 0; i < 12; i++) tick(1'b0, 1'b1, "R3");
        // R2 holds while disabled
        for (int i = 0; i < 5; i++) tick(1'b0, 1'b0, "R2");
        // R4 run up to 99 -> 100
        while (ref_count != 99) tick(1'b0, 1'b1, "R4");
        tick(1'b0, 1'b1, "R4");
        // R6 run to 999 with a pause, then wrap
        while (ref_count != 999) tick(1'b0, 1'b1, "R7");
        tick(1'b0, 1'b0, "R2");
        tick(1'b0, 1'b1, "R6");
        // R7 random enables
        for (int i = 0; i < 4000; i++) tick(1'b0, 1'(($urandom % 4) != 0), "R7");
        // R1 reset in mid-count
        tick(1'b1, 1'b1, "R1");
        // R8 long enabled run, digits compared each cycle
        for (int i = 0; i < 1100; i++) tick(1'b0, 1'b1, "R8");
        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", applied, wrong);
        $finish;
    end

    initial begin
        #(200000 * 4);
        if (!finished) begin
            wrong++;
            $display("FAIL watchdog expired, actual running expected done");
            $display("== %0d vectors applied, %0d miscompares ==", applied, wrong);
            $finish;
        end
    end
endmodule